// File: doc/BRIEF.md
# Voiceband PCM Serial Port with Frame-Sync Width Detection

This block is the serial side of a voiceband PCM port. It runs on a fast system clock and watches an incoming bit clock, a frame sync and a receive data line. In each frame it shifts out one 8-bit transmit word on a tri-statable data output, which it presents as a data bit and a separate output enable. In the same frame it collects one 8-bit receive word and marks it with a strobe.

The frame sync can come in two widths. A short pulse is high across exactly one falling edge of the bit clock. A long pulse stays high across two or more falling edges. The port measures every pulse and applies the matching bit timing to the next frame. After a power-down request is withdrawn, the transmit output stays released for two whole frames so that it cannot collide with other talkers on a shared line.

Companding, filtering and the analog path sit outside this block. The port exchanges plain parallel words with that logic.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset the output enable is low, the strobe is low, the receive word reads 0x00, and short timing is in force until a first pulse has been measured.
- R2: A sync pulse that is high on exactly one bit-clock falling edge makes the following frame use short timing.
- R3: A sync pulse that is high on two or more bit-clock falling edges makes the following frame use long timing. The pulse of the current frame never changes the timing of that same frame.
- R4: Short timing, transmit: the first bit (the MSB) is driven and the output enable rises on the first bit-clock rising edge after the falling edge that saw sync high. Each later rising edge drives the next bit, down to the LSB.
- R5: Short timing, release: the output enable drops on the falling edge in the middle of the LSB, so exactly eight bits are presented.
- R6: Short timing, receive: the data input is sampled MSB first on the eight falling edges that follow the falling edge that saw sync high.
- R7: Long timing, transmit: the MSB is driven on the first rising edge that sees sync high. The output stays enabled while sync is high or while the word is unfinished, and it is released at whichever comes later: the middle of the LSB or sync going low. When sync is held for W > 8 bit periods, W bit times are driven. Bits after the LSB read 0.
- R8: Long timing, receive: the data input is sampled MSB first on eight falling edges, starting with the first falling edge that sees sync high.
- R9: While power-down is high, the output enable is low and sync pulses are ignored. After power-down is released, the first two frames drive nothing. Receive still works in those frames, and the third frame transmits.
- R10: The strobe rises at the capture of the eighth receive bit and stays high for exactly one bit-clock period. The receive word holds its value between strobes.
- R11: The transmit word input is taken at the start of the frame. Changing it after that has no effect on the bits sent in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the bit clock is sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock, synchronous to clk |
| fsync | input | 1 | Frame sync pulse |
| rx_din | input | 1 | Serial receive data |
| pwr_down | input | 1 | Power-down request, active high |
| tx_word | input | WORD_W | Parallel word to send in the next frame |
| tx_dout | output | 1 | Serial transmit data bit |
| tx_oe | output | 1 | Transmit output enable; low means high impedance |
| rx_word | output | WORD_W | Last complete received word |
| rx_valid | output | 1 | Strobe, one bit period long, for a new received word |

## Verification
The bench builds the port with WORD_W = 8 and BLANK_FRAMES = 2, and with a bit clock of eight system clocks. At these values a long pulse wider than the word (ten bit periods) is reachable, and so is the case where release follows sync falling rather than the LSB. The two-frame release blanking can then be checked in full within a few frames. Frames alternate pulse width so that every short/long transition is covered in both directions. This shows that each frame's timing comes from the previous pulse and not from its own.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  typedef enum logic {
    SYNC_SHORT = 1'b0,
    SYNC_LONG  = 1'b1
  } sync_mode_e;

endpackage

// File: rtl/pcm_sync_track.sv
module pcm_sync_track
  import pcm_port_pkg::*;
#(
  parameter int BLANK_FRAMES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bclk,
  input  logic       fsync,
  input  logic       pwr_down,
  output logic       bclk_rise,
  output logic       bclk_fall,
  output logic       frame_start,
  output logic       long_start,
  output sync_mode_e mode,
  output logic       blank
);

  localparam int BLK_W = $clog2(BLANK_FRAMES + 1);

  logic             bclk_q;
  logic             fs_fall_q, fs_fall_d;
  logic             fs_rise_q, fs_rise_d;
  logic [1:0]       width_q, width_d;
  sync_mode_e       mode_q, mode_d;
  logic [BLK_W-1:0] blank_q, blank_d;

  assign bclk_rise   = bclk & ~bclk_q;
  assign bclk_fall   = ~bclk & bclk_q;
  assign frame_start = bclk_fall & fsync & ~fs_fall_q & ~pwr_down;
  assign long_start  = bclk_rise & fsync & ~fs_rise_q & ~pwr_down & (mode_q == SYNC_LONG);
  assign mode        = mode_q;
  assign blank       = (blank_q != '0);

  always_comb begin
    fs_fall_d = fs_fall_q;
    fs_rise_d = fs_rise_q;
    width_d   = width_q;
    mode_d    = mode_q;
    blank_d   = blank_q;
    if (pwr_down) begin
      fs_fall_d = 1'b0;
      fs_rise_d = 1'b0;
      width_d   = '0;
      blank_d   = BLK_W'(BLANK_FRAMES);
    end else begin
      if (bclk_rise) begin
        fs_rise_d = fsync;
      end
      if (bclk_fall) begin
        fs_fall_d = fsync;
        if (fsync) begin
          if (width_q != 2'd3) width_d = width_q + 2'd1;
        end else if (fs_fall_q) begin
          mode_d  = (width_q >= 2'd2) ? SYNC_LONG : SYNC_SHORT;
          width_d = '0;
        end
      end
      if (frame_start && blank_q != '0) begin
        blank_d = blank_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q    <= 1'b0;
      fs_fall_q <= 1'b0;
      fs_rise_q <= 1'b0;
      width_q   <= '0;
      mode_q    <= SYNC_SHORT;
      blank_q   <= '0;
    end else begin
      bclk_q    <= bclk;
      fs_fall_q <= fs_fall_d;
      fs_rise_q <= fs_rise_d;
      width_q   <= width_d;
      mode_q    <= mode_d;
      blank_q   <= blank_d;
    end
  end

  assert_blank_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> blank);

  assert_start_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (bclk_q && !bclk));

endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter
  import pcm_port_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_rise,
  input  logic              bclk_fall,
  input  logic              frame_start,
  input  logic              long_start,
  input  sync_mode_e        mode,
  input  logic              blank,
  input  logic              fsync,
  input  logic              pwr_down,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_dout,
  output logic              tx_oe
);

  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_W - 1);

  logic              act_q, act_d;
  logic              arm_q, arm_d;
  logic              long_q, long_d;
  logic              sup_q, sup_d;
  logic              done_q, done_d;
  logic              oe_q, oe_d;
  logic              bit_q, bit_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              end_now;

  always_comb begin
    act_d   = act_q;
    arm_d   = arm_q;
    long_d  = long_q;
    sup_d   = sup_q;
    done_d  = done_q;
    oe_d    = oe_q;
    bit_d   = bit_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    end_now = 1'b0;
    if (pwr_down) begin
      act_d  = 1'b0;
      arm_d  = 1'b0;
      long_d = 1'b0;
      sup_d  = 1'b0;
      done_d = 1'b0;
      oe_d   = 1'b0;
      bit_d  = 1'b0;
      idx_d  = '0;
    end else if (!act_q) begin
      if (long_start) begin
        act_d  = 1'b1;
        long_d = 1'b1;
        sup_d  = blank;
        oe_d   = ~blank;
        bit_d  = tx_word[WORD_W-1];
        sh_d   = {tx_word[WORD_W-2:0], 1'b0};
        idx_d  = '0;
        done_d = 1'b0;
      end else if (arm_q && bclk_rise) begin
        act_d  = 1'b1;
        arm_d  = 1'b0;
        oe_d   = ~sup_q;
        bit_d  = sh_q[WORD_W-1];
        sh_d   = {sh_q[WORD_W-2:0], 1'b0};
        idx_d  = '0;
        done_d = 1'b0;
      end else if (frame_start && mode == SYNC_SHORT) begin
        arm_d  = 1'b1;
        sh_d   = tx_word;
        sup_d  = blank;
        long_d = 1'b0;
      end
    end else begin
      if (bclk_rise) begin
        if (idx_q != LAST) begin
          idx_d = idx_q + 1'b1;
          bit_d = sh_q[WORD_W-1];
          sh_d  = {sh_q[WORD_W-2:0], 1'b0};
        end else begin
          bit_d = 1'b0;
        end
      end
      if (bclk_fall && idx_q == LAST) begin
        done_d = 1'b1;
      end
      end_now = long_q ? (done_d && !fsync) : (bclk_fall && idx_q == LAST);
      if (end_now) begin
        act_d = 1'b0;
        oe_d  = 1'b0;
        bit_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      arm_q  <= 1'b0;
      long_q <= 1'b0;
      sup_q  <= 1'b0;
      done_q <= 1'b0;
      oe_q   <= 1'b0;
      bit_q  <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
    end else begin
      act_q  <= act_d;
      arm_q  <= arm_d;
      long_q <= long_d;
      sup_q  <= sup_d;
      done_q <= done_d;
      oe_q   <= oe_d;
      bit_q  <= bit_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
    end
  end

  assign tx_dout = bit_q;
  assign tx_oe   = oe_q;

  assert_quiet_in_pd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !tx_oe);

  assert_blanked_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && sup_q) |-> !tx_oe);

  assert_drive_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_oe) |-> $past(bclk_rise));

  assert_release_point_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_oe) |-> $past(bclk_fall || pwr_down || !fsync));

  assert_long_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_oe && long_q && fsync && !pwr_down) |=> tx_oe);

endmodule

// File: rtl/pcm_rx_shifter.sv
module pcm_rx_shifter
  import pcm_port_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_fall,
  input  logic              frame_start,
  input  sync_mode_e        mode,
  input  logic              rx_din,
  input  logic              pwr_down,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              vld_q, vld_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    word_d = word_q;
    vld_d  = vld_q;
    if (pwr_down) begin
      busy_d = 1'b0;
      cnt_d  = '0;
      vld_d  = 1'b0;
    end else if (bclk_fall) begin
      vld_d = 1'b0;
      if (frame_start) begin
        busy_d = 1'b1;
        if (mode == SYNC_LONG) begin
          sh_d  = {sh_q[WORD_W-2:0], rx_din};
          cnt_d = CNT_W'(1);
        end else begin
          cnt_d = '0;
        end
      end else if (busy_q) begin
        sh_d  = {sh_q[WORD_W-2:0], rx_din};
        cnt_d = cnt_q + 1'b1;
        if (cnt_d == FULL) begin
          word_d = sh_d;
          vld_d  = 1'b1;
          busy_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      word_q <= word_d;
      vld_q  <= vld_d;
    end
  end

  assign rx_word  = word_q;
  assign rx_valid = vld_q;

  assert_strobe_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(bclk_fall));

  assert_word_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> (rx_valid || $stable(rx_word)));

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_port_pkg::*;
#(
  parameter int WORD_W       = 8,
  parameter int BLANK_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              fsync,
  input  logic              rx_din,
  input  logic              pwr_down,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_dout,
  output logic              tx_oe,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);

  logic [1:0] rst_pipe;
  logic       core_rst_n;
  logic       bclk_rise, bclk_fall, frame_start, long_start, blank;
  sync_mode_e mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  pcm_sync_track #(.BLANK_FRAMES(BLANK_FRAMES)) u_sync (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .bclk       (bclk),
    .fsync      (fsync),
    .pwr_down   (pwr_down),
    .bclk_rise  (bclk_rise),
    .bclk_fall  (bclk_fall),
    .frame_start(frame_start),
    .long_start (long_start),
    .mode       (mode),
    .blank      (blank)
  );

  pcm_tx_shifter #(.WORD_W(WORD_W)) u_tx (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .bclk_rise  (bclk_rise),
    .bclk_fall  (bclk_fall),
    .frame_start(frame_start),
    .long_start (long_start),
    .mode       (mode),
    .blank      (blank),
    .fsync      (fsync),
    .pwr_down   (pwr_down),
    .tx_word    (tx_word),
    .tx_dout    (tx_dout),
    .tx_oe      (tx_oe)
  );

  pcm_rx_shifter #(.WORD_W(WORD_W)) u_rx (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .bclk_fall  (bclk_fall),
    .frame_start(frame_start),
    .mode       (mode),
    .rx_din     (rx_din),
    .pwr_down   (pwr_down),
    .rx_word    (rx_word),
    .rx_valid   (rx_valid)
  );

endmodule

// File: tb/pcm_serial_port_tb.sv
module pcm_serial_port_tb;

  localparam int W = 8;

  typedef struct {
    logic [W-1:0] word;
    int           len;
    string        tag;
  } tx_exp_t;

  typedef struct {
    logic [W-1:0] word;
    string        tag;
  } rx_exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bclk = 1'b0;
  logic         fsync = 1'b0;
  logic         rx_din = 1'b0;
  logic         pwr_down = 1'b0;
  logic [W-1:0] tx_word = '0;
  logic         tx_dout, tx_oe, rx_valid;
  logic [W-1:0] rx_word;

  int n_checks = 0;
  int n_fail = 0;
  tx_exp_t txq[$];
  rx_exp_t rxq[$];

  always #2.5 clk = ~clk;

  pcm_serial_port #(.WORD_W(W), .BLANK_FRAMES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .rx_din(rx_din),
    .pwr_down(pwr_down), .tx_word(tx_word), .tx_dout(tx_dout), .tx_oe(tx_oe),
    .rx_word(rx_word), .rx_valid(rx_valid)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // one bit period: 8 system clocks, sync/data change 2 clocks before the rise
  task automatic slot(logic f, logic r);
    @(negedge clk); fsync = f; rx_din = r;
    @(negedge clk);
    @(negedge clk); bclk = 1'b1;
    repeat (3) @(negedge clk);
    @(negedge clk); bclk = 1'b0;
    @(negedge clk);
  endtask

  // driver: w = pulse width in falling edges, lng = timing the port must use
  task automatic frame(int w, bit lng, logic [W-1:0] txw, logic [W-1:0] rxw,
                       bit exp_tx, bit exp_rx, bit mangle, string tag);
    tx_exp_t te;
    rx_exp_t re;
    int total;
    total = ((w > 9) ? w : 9) + 1;
    tx_word = txw;
    if (exp_tx) begin
      te.word = txw;
      te.len  = lng ? ((w > 8) ? w : 8) : 8;
      te.tag  = tag;
      txq.push_back(te);
    end
    if (exp_rx) begin
      re.word = rxw;
      re.tag  = tag;
      rxq.push_back(re);
    end
    for (int s = 0; s < total; s++) begin
      logic r;
      r = s[0];
      if (lng && s < 8) r = rxw[7 - s];
      if (!lng && s >= 1 && s <= 8) r = rxw[8 - s];
      if (mangle && s == 2) tx_word = ~txw;
      slot(s < w, r);
    end
    slot(1'b0, 1'b0);
  endtask

  // tx monitor: sample just before each bit-clock fall
  initial begin
    int run = 0;
    logic [W-1:0] got = '0;
    forever begin
      @(negedge bclk);
      if (tx_oe) begin
        if (run < W) got[W-1-run] = tx_dout;
        run++;
      end else if (run > 0) begin
        if (txq.size() == 0) begin
          chk(1'b0, "R9", "unexpected transmit run", run, 0);
        end else begin
          tx_exp_t e;
          e = txq.pop_front();
          chk(got == e.word, e.tag, "tx word", int'(got), int'(e.word));
          chk(run == e.len, e.tag, "tx driven bit count", run, e.len);
        end
        run = 0;
        got = '0;
      end
    end
  end

  // rx monitor
  initial begin
    forever begin
      int n;
      @(posedge rx_valid);
      #1;
      if (rxq.size() == 0) begin
        chk(1'b0, "R9", "unexpected rx strobe", int'(rx_word), 0);
      end else begin
        rx_exp_t e;
        e = rxq.pop_front();
        chk(rx_word == e.word, e.tag, "rx word", int'(rx_word), int'(e.word));
      end
      n = 0;
      @(negedge clk);
      while (rx_valid) begin
        n++;
        @(negedge clk);
      end
      chk(n == 8, "R10", "strobe width in clocks", n, 8);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [W-1:0] hold;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_oe == 1'b0, "R1", "tx_oe after reset", tx_oe, 0);
    chk(rx_valid == 1'b0, "R1", "rx_valid after reset", rx_valid, 0);
    chk(rx_word == '0, "R1", "rx_word after reset", int'(rx_word), 0);
    slot(1'b0, 1'b0);
    slot(1'b0, 1'b0);

    frame(1, 1'b0, 8'hA5, 8'h3C, 1, 1, 0, "R2 R4 R5 R6 first frame short");
    frame(1, 1'b0, 8'h81, 8'hC3, 1, 1, 0, "R2 R4 R6 short");
    frame(3, 1'b0, 8'h5A, 8'h96, 1, 1, 0, "R3 long pulse still short timing");
    frame(3, 1'b1, 8'hE7, 8'h18, 1, 1, 0, "R3 R7 R8 long timing");
    frame(10, 1'b1, 8'h3B, 8'hD2, 1, 1, 0, "R7 wide sync extends drive");
    frame(1, 1'b1, 8'hC6, 8'h6C, 1, 1, 0, "R3 R8 short pulse keeps long once");
    frame(1, 1'b0, 8'h0F, 8'hF0, 1, 1, 1, "R11 R2 word latched short");
    frame(2, 1'b0, 8'h99, 8'h01, 1, 1, 0, "R2 R3 width two short timing");
    frame(1, 1'b1, 8'h42, 8'h80, 1, 1, 1, "R11 R7 word latched long");

    // power-down: output quiet, sync ignored
    pwr_down = 1'b1;
    slot(1'b0, 1'b0);
    chk(tx_oe == 1'b0, "R9", "tx_oe in power-down", tx_oe, 0);
    hold = rx_word;
    frame(1, 1'b0, 8'hFF, 8'h55, 0, 0, 0, "R9 ignored in power-down");
    chk(tx_oe == 1'b0, "R9", "tx_oe after sync in power-down", tx_oe, 0);
    chk(rx_word == hold, "R9", "rx_word kept in power-down", int'(rx_word), int'(hold));
    pwr_down = 1'b0;
    slot(1'b0, 1'b0);
    // mode remained short (last measured pulse was short)
    frame(1, 1'b0, 8'hAA, 8'h11, 0, 1, 0, "R9 blank frame one");
    frame(1, 1'b0, 8'hBB, 8'h22, 0, 1, 0, "R9 blank frame two");
    frame(1, 1'b0, 8'hCC, 8'h33, 1, 1, 0, "R9 third frame drives");
    frame(4, 1'b0, 8'h12, 8'h34, 1, 1, 0, "R3 R4 long pulse after pd");
    frame(4, 1'b1, 8'h56, 8'h78, 1, 1, 0, "R7 R8 long after pd");

    repeat (3) slot(1'b0, 1'b0);
    chk(txq.size() == 0, "R4", "tx items left", txq.size(), 0);
    chk(rxq.size() == 0, "R6", "rx items left", rxq.size(), 0);
    finish_run();
  end

endmodule